// File: doc/BRIEF.md
# Masked Input-Change Interrupt Controller

This block watches a set of already-synchronised pin levels, grouped into banks, and raises an active-low interrupt request when a pin that is configured as an input and not masked differs from the level recorded for it. The recorded levels form a per-bank reference snapshot. The snapshot is refreshed only when the register core reports that software has read that bank's input register. It is also refreshed when the block leaves reset.

Each bank reports its own pending flag. The request is the OR of those flags and passes through one register, so it carries no glitches. A change in several banks keeps the request active until every one of those banks has been read. The request also drops by itself if every changed pin goes back to its snapshot level before any read. The register core supplies the direction bits, the mask bits and the bank-read strobe. A separate alert function can reuse the request.

Top module: `chg_irq_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge (synchronous reset), the snapshot loads the current pin levels. From the edge after reset, `irq_n` is 1 and no pending flag is set. As a result, pins that stay unchanged through reset release raise nothing, even when they are unmasked inputs.
- R2: A pin takes part in change detection only when its direction bit is 1 (input) and its mask bit is 0. An output pin (direction 0) or a masked pin (mask 1) never sets a pending flag, whatever level it has.
- R3: `bank_pend[b]` is set in the same cycle in which any pin of bank b that takes part differs from its snapshot bit. `irq_n` equals the inverse of the OR of all pending flags as it stood one clock earlier.
- R4: If every differing pin returns to its snapshot level before any read, the pending flags clear without a read, and `irq_n` returns to 1 one clock later.
- R5: `rd_stb` high with `rd_bank` = b at a rising edge loads bank b's snapshot with that bank's pins at that edge. This clears bank b's pending flag from that edge on and leaves the snapshot and flags of every other bank untouched.
- R6: When pins in several banks change (for example banks 0, 2 and 3), `irq_n` stays 0 until each of those banks has been read. It rises one clock after the last of those reads.
- R7: Changing a pin from output to input sets its bank's pending flag at once if its level differs from its snapshot bit. The snapshot is not refreshed while a pin acts as an output.
- R8: A read strobe whose `rd_bank` is NUM_BANKS or above changes no snapshot and no pending flag.
- R9: With every mask bit at 1 (the register core's reset value), no pin activity sets a pending flag or drives `irq_n` low.

Pin bit b*BANK_W+i belongs to bank b, bit i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_lvl | input | NUM_BANKS*BANK_W | Synchronised pin levels, raw, with no inversion |
| dir_in | input | NUM_BANKS*BANK_W | Direction per pin, 1 = input |
| irq_mask | input | NUM_BANKS*BANK_W | Interrupt mask per pin, 1 = masked |
| rd_stb | input | 1 | One-cycle strobe: a bank's input register was read |
| rd_bank | input | clog2(NUM_BANKS) | Index of the bank that was read |
| bank_pend | output | NUM_BANKS | Per-bank pending flags |
| irq_n | output | 1 | Registered active-low interrupt request |

## Verification
The bench changes pins in three banks at once and reads them one at a time. A design that cleared everything on the first read would release `irq_n` early. A design that refreshed the wrong bank would leave a flag set after its own read. The bench also makes pins return to their snapshot levels with no read, which catches a sticky latch-style flag, and switches a pin that moved while it was an output over to input, which catches a snapshot that tracks output pins. Out-of-range read indices, masked pins and output pins are toggled to show that they touch nothing. Reset is checked with unmasked inputs held at a non-zero pattern, so a snapshot that reset to zero would fire at once.

// File: rtl/chg_irq_ctrl.sv
module chg_irq_ctrl #(
  parameter int NUM_BANKS = 5,
  parameter int BANK_W    = 8,
  localparam int PINS     = NUM_BANKS * BANK_W,
  localparam int IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PINS-1:0]  pin_lvl,
  input  logic [PINS-1:0]  dir_in,
  input  logic [PINS-1:0]  irq_mask,
  input  logic             rd_stb,
  input  logic [IDX_W-1:0] rd_bank,
  output logic [NUM_BANKS-1:0] bank_pend,
  output logic             irq_n
);

  logic [PINS-1:0] snap_q;
  logic [PINS-1:0] watched;
  logic [PINS-1:0] delta;
  logic            irq_q;

  assign watched = dir_in & ~irq_mask;
  assign delta   = (pin_lvl ^ snap_q) & watched;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = rd_stb && (rd_bank == IDX_W'(b));

    always_ff @(posedge clk) begin
      if (!rst_n || hit)
        snap_q[b*BANK_W +: BANK_W] <= pin_lvl[b*BANK_W +: BANK_W];
    end

    assign bank_pend[b] = |delta[b*BANK_W +: BANK_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b1;
    else        irq_q <= ~|bank_pend;
  end

  assign irq_n = irq_q;

endmodule

// File: rtl/chg_irq_ctrl_chk.sv
module chg_irq_ctrl_chk #(
  parameter int NUM_BANKS = 5,
  parameter int BANK_W    = 8,
  localparam int PINS     = NUM_BANKS * BANK_W,
  localparam int IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [PINS-1:0]      pin_lvl,
  input logic [PINS-1:0]      irq_mask,
  input logic                 rd_stb,
  input logic [IDX_W-1:0]     rd_bank,
  input logic [NUM_BANKS-1:0] bank_pend,
  input logic                 irq_n,
  input logic [PINS-1:0]      snap_q
);

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> irq_n);

  p_irq_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (irq_n == !$past(|bank_pend)));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    p_read_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && rd_bank == IDX_W'(b)) |=>
        snap_q[b*BANK_W +: BANK_W] == $past(pin_lvl[b*BANK_W +: BANK_W]));

    p_snap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_stb && rd_bank == IDX_W'(b)) |=> $stable(snap_q[b*BANK_W +: BANK_W]));

    p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (&irq_mask[b*BANK_W +: BANK_W]) |-> !bank_pend[b]);
  end

endmodule

bind chg_irq_ctrl chg_irq_ctrl_chk #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .irq_mask(irq_mask),
  .rd_stb(rd_stb), .rd_bank(rd_bank), .bank_pend(bank_pend),
  .irq_n(irq_n), .snap_q(snap_q)
);

// File: tb/chg_irq_ctrl_tb.sv
module chg_irq_ctrl_tb;
  localparam int NB = 5;
  localparam int BW = 8;
  localparam int P  = NB * BW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [P-1:0]  pins = '0;
  logic [P-1:0]  dir  = '1;
  logic [P-1:0]  msk  = '1;
  logic          rd_stb = 1'b0;
  logic [2:0]    rd_bank = '0;
  logic [NB-1:0] pend;
  logic          irq_n;

  logic [P-1:0]  exp_snap;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  chg_irq_ctrl #(.NUM_BANKS(NB), .BANK_W(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pins), .dir_in(dir), .irq_mask(msk),
    .rd_stb(rd_stb), .rd_bank(rd_bank), .bank_pend(pend), .irq_n(irq_n)
  );

  function automatic logic [NB-1:0] model_pend();
    logic [NB-1:0] r;
    logic [P-1:0]  d;
    d = (pins ^ exp_snap) & dir & ~msk;
    for (int b = 0; b < NB; b++) r[b] = |d[b*BW +: BW];
    return r;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle(); #1; endtask

  task automatic rd(int b);
    @(negedge clk);
    rd_stb = 1'b1; rd_bank = 3'(b);
    @(negedge clk);
    rd_stb = 1'b0;
    if (b < NB) exp_snap[b*BW +: BW] = pins[b*BW +: BW];
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    pins = 40'hA5_3C_96_0F_E1;
    exp_snap = pins;
    repeat (2) @(negedge clk);
    chk("R1 irq_n in reset", 64'(irq_n), 64'd1);
    rst_n = 1'b1;
    msk = '0; dir = '1;
    settle();
    chk("R1 pend after reset with unmasked inputs", 64'(pend), 64'd0);
    @(negedge clk);
    chk("R1 irq_n after reset", 64'(irq_n), 64'd1);
  endtask

  task automatic t_mask_all();
    msk = '1;
    @(negedge clk);
    pins = ~pins;
    settle();
    chk("R9 pend with all masked", 64'(pend), 64'd0);
    @(negedge clk);
    chk("R9 irq_n with all masked", 64'(irq_n), 64'd1);
    pins = exp_snap;
    msk = '0;
    @(negedge clk);
  endtask

  task automatic t_qualify();
    dir[1*BW+2] = 1'b0;
    msk[3*BW+5] = 1'b1;
    pins[1*BW+2] = ~pins[1*BW+2];
    pins[3*BW+5] = ~pins[3*BW+5];
    settle();
    chk("R2 output and masked pins ignored", 64'(pend), 64'd0);
    pins[4*BW+7] = ~pins[4*BW+7];
    settle();
    chk("R2 qualifying pin sets its bank only", 64'(pend), 64'b10000);
    pins[4*BW+7] = exp_snap[4*BW+7];
    pins[3*BW+5] = exp_snap[3*BW+5];
    msk[3*BW+5] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_return();
    @(negedge clk);
    pins[2*BW+1] = ~pins[2*BW+1];
    settle();
    chk("R3 pend same cycle", 64'(pend), 64'b00100);
    chk("R3 irq_n not yet low", 64'(irq_n), 64'd1);
    @(negedge clk);
    chk("R3 irq_n low one clock later", 64'(irq_n), 64'd0);
    pins[2*BW+1] = exp_snap[2*BW+1];
    settle();
    chk("R4 pend clears on return", 64'(pend), 64'd0);
    @(negedge clk);
    chk("R4 irq_n released after return", 64'(irq_n), 64'd1);
  endtask

  task automatic t_multi();
    pins[0*BW+5] = ~pins[0*BW+5];
    pins[2*BW+3] = ~pins[2*BW+3];
    pins[3*BW+7] = ~pins[3*BW+7];
    settle();
    chk("R6 three banks pending", 64'(pend), 64'b01101);
    rd(0);
    chk("R5 read bank 0 clears only bank 0", 64'(pend), 64'b01100);
    chk("R6 irq_n still low after first read", 64'(irq_n), 64'd0);
    rd(2);
    chk("R5 read bank 2", 64'(pend), 64'b01000);
    chk("R6 irq_n low before last read", 64'(irq_n), 64'd0);
    rd(3);
    chk("R5 model agrees after reads", 64'(pend), 64'(model_pend()));
    chk("R6 irq_n low on edge of last read", 64'(irq_n), 64'd0);
    @(negedge clk);
    chk("R6 irq_n high one clock after last read", 64'(irq_n), 64'd1);
  endtask

  task automatic t_oob();
    pins[1*BW+6] = ~pins[1*BW+6];
    rd(6);
    chk("R8 out-of-range read ignored", 64'(pend), 64'b00010);
    rd(5);
    chk("R8 index NUM_BANKS ignored", 64'(pend), 64'b00010);
    chk("R8 irq_n held", 64'(irq_n), 64'd0);
    rd(1);
    chk("R5 read bank 1 clears", 64'(pend), 64'd0);
    @(negedge clk);
  endtask

  task automatic t_dir_switch();
    dir[1*BW+2] = 1'b0;
    pins[1*BW+2] = ~exp_snap[1*BW+2];
    @(negedge clk);
    rd(0);
    chk("R7 output pin quiet", 64'(pend), 64'd0);
    dir[1*BW+2] = 1'b1;
    settle();
    chk("R7 switch to input raises pend", 64'(pend), 64'b00010);
    @(negedge clk);
    chk("R7 irq_n low after switch", 64'(irq_n), 64'd0);
    rd(1);
    chk("R7 cleared by read", 64'(pend), 64'd0);
  endtask

  initial begin
    t_reset();
    t_mask_all();
    t_qualify();
    t_return();
    t_multi();
    t_oob();
    t_dir_switch();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule